// File: doc/BRIEF.md
# PTP Event Timestamp Capture

This block records the system time at the moment an event message of the Precision Time Protocol passes the start-of-frame point of the receive or transmit path. The receive path is classified from header fields that an upstream parser has already extracted: ethertype, a UDP flag with destination port, protocol version and message type. The transmit path captures only for a frame that the descriptor logic has marked for stamping.

Each direction owns a 64-bit stamp and a valid flag. A captured stamp stays locked, and later event frames pass through unstamped, until software reads the high stamp word. That read is the only release, so a stamped frame that is later dropped still leaves the lock set until software clears it. The receive classifier has three modes: off, a version 1 UDP mode that accepts one programmed message type on the event port, and a version 2 mode that accepts every event message over UDP or over a layer-2 ethertype filter.

Top module: `ptp_stamp_latch`

## Requirements
- R1: A qualifying receive frame, with `rx_sof` high in cycle N while the receive stamp is not valid and `rx_rd_hi` is low, loads `sys_time` of cycle N into `rx_stamp`, and `rx_valid` reads 1 from cycle N+1.
- R2: While `rx_valid` (or `tx_valid`) is 1, a qualifying frame leaves the stamp unchanged and the valid flag set.
- R3: A one-cycle `rx_rd_hi` (or `tx_rd_hi`) pulse clears the matching valid flag in the next cycle; the stamp value itself is kept, and a new capture is possible afterwards.
- R4: With `rx_en` low no receive capture occurs; with `tx_en` low no transmit capture occurs.
- R5: A transmit capture occurs on `tx_sof` only when `tx_mark` is high; an unmarked frame never stamps, and only one marked frame is held at a time.
- R6: In mode 1 (`rx_mode` = 01) a frame is captured only if it is UDP to the event port, has version 1, and its message type equals `match_cfg[3:0]` (0 = Sync, 1 = Delay_Req).
- R7: The event port is `match_cfg[31:16]`; a value of zero there selects the default port 319.
- R8: In mode 2 (`rx_mode` = 10) every version 2 event message, types 0 to 3 (Sync, Delay_Req, Pdelay_Req, Pdelay_Resp), is captured; types 8 and above are not.
- R9: In mode 2 a non-UDP frame is captured only when `l2_filt[31]` (enable) and `l2_filt[30]` (stamp) are both set and `rx_etype` equals `l2_filt[15:0]` (0x88F7 in use).
- R10: With `rx_mode` 00 or 11 no receive capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Current system time |
| rx_en | input | 1 | Receive capture enable |
| tx_en | input | 1 | Transmit capture enable |
| rx_mode | input | 2 | Receive filter mode: 00 off, 01 v1 UDP, 10 v2 event, 11 off |
| match_cfg | input | 32 | [31:16] event UDP port (0 = 319), [3:0] v1 message type |
| l2_filt | input | 32 | [31] enable, [30] stamp, [15:0] ethertype |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_etype | input | 16 | Frame ethertype |
| rx_is_udp | input | 1 | Frame carries UDP |
| rx_udp_dport | input | 16 | UDP destination port |
| rx_ptp_ver | input | 4 | PTP version field |
| rx_msg_type | input | 4 | PTP message type |
| rx_rd_hi | input | 1 | Software read of receive stamp high word |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Frame is marked for stamping |
| tx_rd_hi | input | 1 | Software read of transmit stamp high word |
| rx_stamp | output | 64 | Receive stamp |
| rx_valid | output | 1 | Receive stamp valid (locked) |
| tx_stamp | output | 64 | Transmit stamp |
| tx_valid | output | 1 | Transmit stamp valid (locked) |

## Verification
The hardest case is the locked state: a second qualifying frame must arrive while an earlier stamp is still unread, and its time must be visibly different so an overwrite would show. The bench captures at one time value, sends further qualifying frames with new time values, checks the old stamp survives, then pulses the high-word read and confirms a fresh capture takes the newest time.

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch #(
  parameter int TW       = 64,
  parameter int DEF_PORT = 319
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sys_time,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic [1:0]    rx_mode,
  input  logic [31:0]   match_cfg,
  input  logic [31:0]   l2_filt,
  input  logic          rx_sof,
  input  logic [15:0]   rx_etype,
  input  logic          rx_is_udp,
  input  logic [15:0]   rx_udp_dport,
  input  logic [3:0]    rx_ptp_ver,
  input  logic [3:0]    rx_msg_type,
  input  logic          rx_rd_hi,
  input  logic          tx_sof,
  input  logic          tx_mark,
  input  logic          tx_rd_hi,
  output logic [TW-1:0] rx_stamp,
  output logic          rx_valid,
  output logic [TW-1:0] tx_stamp,
  output logic          tx_valid
);
  localparam logic [1:0] MODE_V1 = 2'b01;
  localparam logic [1:0] MODE_V2 = 2'b10;
  localparam logic [15:0] DPORT  = 16'(DEF_PORT);

  logic [15:0] evt_port;
  logic        l4_ok, l2_ok, v1_hit, v2_hit, rx_hit, rx_cap, tx_cap;

  assign evt_port = (match_cfg[31:16] == 16'd0) ? DPORT : match_cfg[31:16];
  assign l4_ok    = rx_is_udp && (rx_udp_dport == evt_port);
  assign l2_ok    = !rx_is_udp && l2_filt[31] && l2_filt[30] &&
                    (rx_etype == l2_filt[15:0]);
  assign v1_hit   = (rx_mode == MODE_V1) && l4_ok && (rx_ptp_ver == 4'd1) &&
                    (rx_msg_type == match_cfg[3:0]);
  assign v2_hit   = (rx_mode == MODE_V2) && (rx_ptp_ver == 4'd2) &&
                    (rx_msg_type < 4'd4) && (l4_ok || l2_ok);
  assign rx_hit   = rx_en && rx_sof && (v1_hit || v2_hit);
  assign rx_cap   = rx_hit && !rx_valid && !rx_rd_hi;
  assign tx_cap   = tx_en && tx_sof && tx_mark && !tx_valid && !tx_rd_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_stamp <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_cap) rx_stamp <= sys_time;
      if (rx_rd_hi)    rx_valid <= 1'b0;
      else if (rx_cap) rx_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_stamp <= '0;
      tx_valid <= 1'b0;
    end else begin
      if (tx_cap) tx_stamp <= sys_time;
      if (tx_rd_hi)    tx_valid <= 1'b0;
      else if (tx_cap) tx_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ptp_stamp_latch_chk.sv
module ptp_stamp_latch_chk #(
  parameter int TW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] sys_time,
  input logic          rx_en,
  input logic          tx_en,
  input logic [1:0]    rx_mode,
  input logic          rx_sof,
  input logic          tx_sof,
  input logic          tx_mark,
  input logic          rx_rd_hi,
  input logic          tx_rd_hi,
  input logic          rx_cap,
  input logic          tx_cap,
  input logic [TW-1:0] rx_stamp,
  input logic          rx_valid,
  input logic [TW-1:0] tx_stamp,
  input logic          tx_valid
);
  a_r1_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cap |=> rx_valid && (rx_stamp == $past(sys_time)));
  a_r2_rx_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_rd_hi |=> rx_valid && $stable(rx_stamp));
  a_r2_tx_locked: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_rd_hi |=> tx_valid && $stable(tx_stamp));
  a_r3_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_hi |=> !rx_valid);
  a_r3_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rd_hi |=> !tx_valid);
  a_r4_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !$rose(rx_valid));
  a_r4_tx_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !$rose(tx_valid));
  a_r5_tx_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_sof && tx_mark) |=> !$rose(tx_valid));
  a_r5_tx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cap |=> tx_valid && (tx_stamp == $past(sys_time)));
  a_r10_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b00 || rx_mode == 2'b11 || !rx_sof) |=> !$rose(rx_valid));
endmodule

bind ptp_stamp_latch ptp_stamp_latch_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .rx_en(rx_en),
  .tx_en(tx_en), .rx_mode(rx_mode), .rx_sof(rx_sof), .tx_sof(tx_sof),
  .tx_mark(tx_mark), .rx_rd_hi(rx_rd_hi), .tx_rd_hi(tx_rd_hi),
  .rx_cap(rx_cap), .tx_cap(tx_cap), .rx_stamp(rx_stamp),
  .rx_valid(rx_valid), .tx_stamp(tx_stamp), .tx_valid(tx_valid)
);

// File: tb/test_ptp_stamp_latch.sv
module test_ptp_stamp_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = '0;
  logic        rx_en = 1'b0, tx_en = 1'b0;
  logic [1:0]  rx_mode = 2'b00;
  logic [31:0] match_cfg = '0, l2_filt = '0;
  logic        rx_sof = 1'b0, rx_is_udp = 1'b0, rx_rd_hi = 1'b0;
  logic [15:0] rx_etype = '0, rx_udp_dport = '0;
  logic [3:0]  rx_ptp_ver = '0, rx_msg_type = '0;
  logic        tx_sof = 1'b0, tx_mark = 1'b0, tx_rd_hi = 1'b0;
  logic [63:0] rx_stamp, tx_stamp;
  logic        rx_valid, tx_valid;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ptp_stamp_latch i_ptp_stamp_latch (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .rx_en(rx_en),
    .tx_en(tx_en), .rx_mode(rx_mode), .match_cfg(match_cfg),
    .l2_filt(l2_filt), .rx_sof(rx_sof), .rx_etype(rx_etype),
    .rx_is_udp(rx_is_udp), .rx_udp_dport(rx_udp_dport),
    .rx_ptp_ver(rx_ptp_ver), .rx_msg_type(rx_msg_type),
    .rx_rd_hi(rx_rd_hi), .tx_sof(tx_sof), .tx_mark(tx_mark),
    .tx_rd_hi(tx_rd_hi), .rx_stamp(rx_stamp), .rx_valid(rx_valid),
    .tx_stamp(tx_stamp), .tx_valid(tx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [63:0] t, input logic udp,
                         input logic [15:0] port, input logic [15:0] et,
                         input logic [3:0] ver, input logic [3:0] msg);
    @(negedge clk);
    sys_time = t; rx_sof = 1'b1; rx_is_udp = udp; rx_udp_dport = port;
    rx_etype = et; rx_ptp_ver = ver; rx_msg_type = msg;
    @(negedge clk);
    rx_sof = 1'b0; sys_time = t + 64'd5;
  endtask

  task automatic send_tx(input logic [63:0] t, input logic mark);
    @(negedge clk);
    sys_time = t; tx_sof = 1'b1; tx_mark = mark;
    @(negedge clk);
    tx_sof = 1'b0; tx_mark = 1'b0; sys_time = t + 64'd5;
  endtask

  task automatic rd_rx();
    @(negedge clk); rx_rd_hi = 1'b1;
    @(negedge clk); rx_rd_hi = 1'b0;
  endtask

  task automatic rd_tx();
    @(negedge clk); tx_rd_hi = 1'b1;
    @(negedge clk); tx_rd_hi = 1'b0;
  endtask

  task automatic t_reset();
    chk(rx_valid == 1'b0, "R1 reset rx_valid", 64'(rx_valid), 0);
    chk(tx_valid == 1'b0, "R5 reset tx_valid", 64'(tx_valid), 0);
    chk(rx_stamp == 64'd0, "R1 reset rx_stamp", rx_stamp, 0);
  endtask

  task automatic t_v2_l4();
    rx_en = 1'b1; rx_mode = 2'b10; match_cfg = '0;
    send_rx(64'd100, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd0);
    chk(rx_valid == 1'b1, "R1 capture valid", 64'(rx_valid), 1);
    chk(rx_stamp == 64'd100, "R7 default port stamp", rx_stamp, 100);
    rd_rx();
    chk(rx_valid == 1'b0, "R3 read clears valid", 64'(rx_valid), 0);
    chk(rx_stamp == 64'd100, "R3 stamp kept", rx_stamp, 100);
  endtask

  task automatic t_lock();
    send_rx(64'h1_0000_0000, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd1);
    send_rx(64'd200, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd1);
    chk(rx_stamp == 64'h1_0000_0000, "R2 locked stamp", rx_stamp, 64'h1_0000_0000);
    chk(rx_valid == 1'b1, "R2 locked valid", 64'(rx_valid), 1);
    rd_rx();
    send_rx(64'd300, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd1);
    chk(rx_stamp == 64'd300, "R3 capture after release", rx_stamp, 300);
    rd_rx();
  endtask

  task automatic t_v2_types();
    send_rx(64'd400, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd8);
    chk(rx_valid == 1'b0, "R8 general msg ignored", 64'(rx_valid), 0);
    send_rx(64'd410, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd3);
    chk(rx_stamp == 64'd410, "R8 pdelay resp stamped", rx_stamp, 410);
    rd_rx();
    send_rx(64'd420, 1'b1, 16'd320, 16'h0800, 4'd2, 4'd0);
    chk(rx_valid == 1'b0, "R7 wrong port ignored", 64'(rx_valid), 0);
  endtask

  task automatic t_v2_l2();
    l2_filt = {1'b1, 1'b1, 14'd0, 16'h88F7};
    send_rx(64'd500, 1'b0, 16'd0, 16'h88F7, 4'd2, 4'd2);
    chk(rx_stamp == 64'd500 && rx_valid, "R9 layer-2 stamped", rx_stamp, 500);
    rd_rx();
    l2_filt = {1'b1, 1'b0, 14'd0, 16'h88F7};
    send_rx(64'd510, 1'b0, 16'd0, 16'h88F7, 4'd2, 4'd2);
    chk(rx_valid == 1'b0, "R9 stamp bit off", 64'(rx_valid), 0);
    l2_filt = {1'b1, 1'b1, 14'd0, 16'h88F7};
    send_rx(64'd520, 1'b0, 16'd0, 16'h88F8, 4'd2, 4'd2);
    chk(rx_valid == 1'b0, "R9 ethertype mismatch", 64'(rx_valid), 0);
  endtask

  task automatic t_v1();
    rx_mode = 2'b01; match_cfg = {16'd320, 12'd0, 4'd1};
    send_rx(64'd600, 1'b1, 16'd320, 16'h0800, 4'd1, 4'd0);
    chk(rx_valid == 1'b0, "R6 other type ignored", 64'(rx_valid), 0);
    send_rx(64'd610, 1'b1, 16'd319, 16'h0800, 4'd1, 4'd1);
    chk(rx_valid == 1'b0, "R7 programmed port only", 64'(rx_valid), 0);
    send_rx(64'd620, 1'b1, 16'd320, 16'h0800, 4'd2, 4'd1);
    chk(rx_valid == 1'b0, "R6 version 2 ignored", 64'(rx_valid), 0);
    send_rx(64'd630, 1'b0, 16'd0, 16'h88F7, 4'd1, 4'd1);
    chk(rx_valid == 1'b0, "R6 layer-2 ignored", 64'(rx_valid), 0);
    send_rx(64'd640, 1'b1, 16'd320, 16'h0800, 4'd1, 4'd1);
    chk(rx_stamp == 64'd640 && rx_valid, "R6 delay req stamped", rx_stamp, 640);
    rd_rx();
  endtask

  task automatic t_disable();
    rx_en = 1'b0; rx_mode = 2'b10; match_cfg = '0;
    send_rx(64'd700, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd0);
    chk(rx_valid == 1'b0, "R4 rx disabled", 64'(rx_valid), 0);
    rx_en = 1'b1; rx_mode = 2'b00;
    send_rx(64'd710, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd0);
    chk(rx_valid == 1'b0, "R10 mode off", 64'(rx_valid), 0);
    rx_mode = 2'b11;
    send_rx(64'd720, 1'b1, 16'd319, 16'h0800, 4'd2, 4'd0);
    chk(rx_valid == 1'b0, "R10 mode reserved", 64'(rx_valid), 0);
    tx_en = 1'b0;
    send_tx(64'd730, 1'b1);
    chk(tx_valid == 1'b0, "R4 tx disabled", 64'(tx_valid), 0);
  endtask

  task automatic t_tx();
    tx_en = 1'b1;
    send_tx(64'd800, 1'b0);
    chk(tx_valid == 1'b0, "R5 unmarked ignored", 64'(tx_valid), 0);
    send_tx(64'd810, 1'b1);
    chk(tx_stamp == 64'd810 && tx_valid, "R5 marked stamped", tx_stamp, 810);
    send_tx(64'd820, 1'b1);
    chk(tx_stamp == 64'd810, "R2 tx locked", tx_stamp, 810);
    rd_tx();
    chk(tx_valid == 1'b0, "R3 tx read clears", 64'(tx_valid), 0);
    send_tx(64'd830, 1'b1);
    chk(tx_stamp == 64'd830, "R5 tx after release", tx_stamp, 830);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_v2_l4();
    t_lock();
    t_v2_types();
    t_v2_l2();
    t_v1();
    t_disable();
    t_tx();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule